// File: doc/BRIEF.md
# SD Host Interrupt Status Register

This block holds the interrupt status flags of an SD/SDIO host controller and drives one interrupt line toward the host processor. It watches four live levels: card presence, buffer readable, buffer writable, and an already-sampled card interrupt request. It turns each of them into a sticky status bit. Software reads the 16-bit status word and clears a flag by writing a 1 to its position.

Flags come in two kinds. The buffer flags are set only on a rising edge of their source level. A clear removes them for good until the next edge. The presence flags and the card interrupt flag also set on an event, but a clear does not remove them while their source condition still holds. Two masks gate every flag. A status-enable mask decides whether a bit may hold a value at all. A signal-enable mask decides whether a set bit reaches the interrupt line.

Top module: `sdhost_irq_status`

## Requirements
- R1: While reset is active, and right after it, every status bit and the interrupt output are 0.
- R2: The flag positions are write-ready at bit 4, read-ready at bit 5, card inserted at bit 6, card removed at bit 7 and card interrupt at bit 8. Bits 15..9 and 3..0 of the status word always read 0.
- R3: A write with data bit k at 1 clears status bit k at the next clock. A write with data bit k at 0 leaves bit k unchanged.
- R4: Bit 6 sets one clock after the card-present level goes 0 to 1. Bit 7 sets one clock after it goes 1 to 0.
- R5: A clear of bit 6 while a card is present leaves bit 6 set. A clear of bit 7 while no card is present leaves bit 7 set. With the opposite presence, the clear takes effect.
- R6: Bit 8 sets one clock after any cycle with the card interrupt request at 1. A clear leaves it set while the request is 1. It stays clear only when the request is 0 at the clear.
- R7: Bit 5 sets on a 0 to 1 change of the buffer-readable level, and bit 4 sets on a 0 to 1 change of the buffer-writable level. A level that stays high or falls does not set the bit again after a clear.
- R8: When status-enable bit k is 0, status bit k reads 0 at the next clock and latches no event. Re-enabling it sets nothing without a new event.
- R9: The interrupt output is 1 exactly when some status bit and its signal-enable bit are both 1. In particular, a set bit 8 with signal-enable bit 8 at 0 does not raise it.
- R10: When a set event and a clear of the same bit fall in one cycle, the bit is set afterwards.
- R11: A card-present level already at 1 when reset ends sets bit 6 at the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| card_present_i | input | 1 | Live card-present level |
| rd_avail_i | input | 1 | Buffer readable level |
| wr_avail_i | input | 1 | Buffer writable level |
| card_irq_req_i | input | 1 | Sampled card interrupt request, level |
| stat_en_i | input | 16 | Per-bit status-enable mask |
| sig_en_i | input | 16 | Per-bit signal-enable mask |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data, a 1 clears that bit |
| status_o | output | 16 | Status word |
| host_irq_o | output | 1 | Host interrupt line |

## Verification
The presence input is driven through insertion, removal and a level already high when reset ends. Each of these is paired with clears under both presence states, which separates edge-set behaviour from re-arming behaviour. The buffer levels are raised, held high and dropped across clears, and one clear lands in the same cycle as a rising edge. This shows that only rising edges set those flags and that a set beats a clear. The card request is cleared once while still active and once after it has dropped. Status-enable and signal-enable masks are toggled bit by bit, which tells apart a flag that is held at zero from a flag that is set but kept off the interrupt line.

// File: rtl/sdhost_irq_pkg.sv
package sdhost_irq_pkg;

    localparam int unsigned REG_W      = 16;
    localparam int unsigned NUM_FLAGS  = 5;
    localparam int unsigned NUM_LEVELS = 3;
    localparam int unsigned POS_BASE   = 4;

    // flag index order: write-ready, read-ready, inserted, removed, card irq
    localparam int unsigned F_WR_RDY   = 0;
    localparam int unsigned F_RD_RDY   = 1;
    localparam int unsigned F_INSERT   = 2;
    localparam int unsigned F_REMOVE   = 3;
    localparam int unsigned F_CARD_IRQ = 4;

    // tracked level index order
    localparam int unsigned L_PRESENT  = 0;
    localparam int unsigned L_RD       = 1;
    localparam int unsigned L_WR       = 2;

    // status word position of a flag (software decodes these)
    function automatic int unsigned flag_pos(input int unsigned idx);
        return POS_BASE + idx;
    endfunction

    // flags that set again on a clear while their condition persists
    function automatic bit flag_rearms(input int unsigned idx);
        return (idx == F_INSERT) || (idx == F_REMOVE) || (idx == F_CARD_IRQ);
    endfunction

endpackage

// File: rtl/sdh_level_edge.sv
module sdh_level_edge #(
    parameter int unsigned W = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [W-1:0] hist;
    } edge_state_t;

    edge_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.hist = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_det
        assign rise_o[g] =  lvl_i[g] & ~state_q.hist[g];
        assign fall_o[g] = ~lvl_i[g] &  state_q.hist[g];
    end

endmodule

// File: rtl/sdh_status_flag.sv
module sdh_status_flag #(
    parameter bit REARM = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic event_i,
    input  logic cond_i,
    input  logic clear_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t state_d, state_q;
    logic        set_w;

    if (REARM) begin : g_rearm
        // a clear while the condition holds is overridden by a fresh set
        assign set_w = event_i | (clear_i & cond_i);
    end else begin : g_edge
        logic unused_cond;
        assign unused_cond = cond_i;
        assign set_w       = event_i;
    end

    always_comb begin
        state_d = state_q;
        if (!enable_i) begin
            state_d.flag = 1'b0;
        end else if (set_w) begin
            state_d.flag = 1'b1;
        end else if (clear_i) begin
            state_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o = state_q.flag;

endmodule

// File: rtl/sdh_irq_combine.sv
module sdh_irq_combine #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    logic [W-1:0] gated;

    for (genvar g = 0; g < W; g++) begin : g_gate
        assign gated[g] = status_i[g] & mask_i[g];
    end

    assign irq_o = |gated;

endmodule

// File: rtl/sdhost_irq_status.sv
module sdhost_irq_status
    import sdhost_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             card_present_i,
    input  logic             rd_avail_i,
    input  logic             wr_avail_i,
    input  logic             card_irq_req_i,
    input  logic [REG_W-1:0] stat_en_i,
    input  logic [REG_W-1:0] sig_en_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] status_o,
    output logic             host_irq_o
);

    logic [NUM_LEVELS-1:0] levels;
    logic [NUM_LEVELS-1:0] rise;
    logic [NUM_LEVELS-1:0] fall;
    logic [NUM_FLAGS-1:0]  ev;
    logic [NUM_FLAGS-1:0]  cond;
    logic [NUM_FLAGS-1:0]  flags;
    logic [REG_W-1:0]      status_word;

    always_comb begin
        levels            = '0;
        levels[L_PRESENT] = card_present_i;
        levels[L_RD]      = rd_avail_i;
        levels[L_WR]      = wr_avail_i;
    end

    sdh_level_edge #(
        .W (NUM_LEVELS)
    ) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (levels),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        ev   = '0;
        cond = '0;
        ev[F_WR_RDY]     = rise[L_WR];
        cond[F_WR_RDY]   = wr_avail_i;
        ev[F_RD_RDY]     = rise[L_RD];
        cond[F_RD_RDY]   = rd_avail_i;
        ev[F_INSERT]     = rise[L_PRESENT];
        cond[F_INSERT]   = card_present_i;
        ev[F_REMOVE]     = fall[L_PRESENT];
        cond[F_REMOVE]   = ~card_present_i;
        ev[F_CARD_IRQ]   = card_irq_req_i;
        cond[F_CARD_IRQ] = card_irq_req_i;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam int unsigned P = flag_pos(i);
        sdh_status_flag #(
            .REARM (flag_rearms(i))
        ) u_flag (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .enable_i (stat_en_i[P]),
            .event_i  (ev[i]),
            .cond_i   (cond[i]),
            .clear_i  (wr_en_i & wr_data_i[P]),
            .flag_o   (flags[i])
        );
    end

    always_comb begin
        status_word = '0;
        for (int unsigned i = 0; i < NUM_FLAGS; i++) begin
            status_word[flag_pos(i)] = flags[i];
        end
    end

    sdh_irq_combine #(
        .W (REG_W)
    ) u_irq (
        .status_i (status_word),
        .mask_i   (sig_en_i),
        .irq_o    (host_irq_o)
    );

    assign status_o = status_word;

endmodule

// File: rtl/sdhost_irq_status_chk.sv
module sdhost_irq_status_chk
    import sdhost_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             card_present_i,
    input  logic             rd_avail_i,
    input  logic             wr_avail_i,
    input  logic             card_irq_req_i,
    input  logic [REG_W-1:0] stat_en_i,
    input  logic [REG_W-1:0] sig_en_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [REG_W-1:0] status_o,
    input  logic             host_irq_o
);

    logic pres_prev, rd_prev, wr_prev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pres_prev <= 1'b0;
            rd_prev   <= 1'b0;
            wr_prev   <= 1'b0;
        end else begin
            pres_prev <= card_present_i;
            rd_prev   <= rd_avail_i;
            wr_prev   <= wr_avail_i;
        end
    end

    p_unused_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[15:9] == '0) && (status_o[3:0] == '0));

    p_clear_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[5] && !(rd_avail_i && !rd_prev)) |=> !status_o[5]);

    p_hold_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[5] && stat_en_i[5] && !(wr_en_i && wr_data_i[5])) |=> status_o[5]);

    p_insert_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_en_i[6] && card_present_i && !pres_prev) |=> status_o[6]);

    p_remove_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_en_i[7] && !card_present_i && pres_prev) |=> status_o[7]);

    p_remove_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_en_i[7] && status_o[7] && !card_present_i) |=> status_o[7]);

    p_card_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_en_i[8] && card_irq_req_i) |=> status_o[8]);

    p_wr_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_en_i[4] && wr_avail_i && !wr_prev) |=> status_o[4]);

    p_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stat_en_i[8] || !stat_en_i[6]) |=> (!status_o[8] || !status_o[6]));

    p_irq_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_o & sig_en_i) == '0) |-> !host_irq_o);

    p_irq_raise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[8] && sig_en_i[8]) |-> host_irq_o);

endmodule

bind sdhost_irq_status sdhost_irq_status_chk u_chk (.*);

// File: tb/test_sdhost_irq_status.sv
`timescale 1ns/1ps
module test_sdhost_irq_status;

    localparam int unsigned W = 16;
    localparam logic [W-1:0] WRR = 16'h0010;
    localparam logic [W-1:0] RDR = 16'h0020;
    localparam logic [W-1:0] INS = 16'h0040;
    localparam logic [W-1:0] REM = 16'h0080;
    localparam logic [W-1:0] CIR = 16'h0100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         present = 1'b0;
    logic         rd = 1'b0;
    logic         wr = 1'b0;
    logic         creq = 1'b0;
    logic [W-1:0] sten = '1;
    logic [W-1:0] sgen = '0;
    logic         wen = 1'b0;
    logic [W-1:0] wdat = '0;
    logic [W-1:0] status;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] q_st[$];
    bit           q_irq[$];
    string        q_tag[$];

    always #10 clk = ~clk;

    sdhost_irq_status i_sdhost_irq_status (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .card_present_i (present),
        .rd_avail_i     (rd),
        .wr_avail_i     (wr),
        .card_irq_req_i (creq),
        .stat_en_i      (sten),
        .sig_en_i       (sgen),
        .wr_en_i        (wen),
        .wr_data_i      (wdat),
        .status_o       (status),
        .host_irq_o     (irq)
    );

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        if (q_st.size() != 0) begin
            logic [W-1:0] es;
            bit           ei;
            string        t;
            es = q_st.pop_front();
            ei = q_irq.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (status !== es || irq !== ei) begin
                errors++;
                $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                         t, status, irq, es, ei);
            end
        end
    end

    // driver: one clock with current inputs, then queue the expectation
    task automatic cyc(input logic [W-1:0] es, input bit ei, input string t);
        @(posedge clk);
        #1;
        q_st.push_back(es);
        q_irq.push_back(ei);
        q_tag.push_back(t);
        @(negedge clk);
        #1;
        wen  = 1'b0;
        wdat = '0;
    endtask

    task automatic clr(input logic [W-1:0] d);
        wen  = 1'b1;
        wdat = d;
    endtask

    initial begin
        present = 1'b1;
        cyc('0, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        cyc(INS, 1'b0, "R11 present at reset end");
        clr(INS);
        cyc(INS, 1'b0, "R5 insert clear while present");
        sten[6] = 1'b0;
        cyc('0, 1'b0, "R8 disabled insert held 0");
        sten[6] = 1'b1;
        cyc('0, 1'b0, "R8 re-enable sets nothing");
        present = 1'b0;
        cyc(REM, 1'b0, "R4 removal edge");
        clr(REM);
        cyc(REM, 1'b0, "R5 removal clear while absent");
        present = 1'b1;
        cyc(REM | INS, 1'b0, "R4 insertion edge");
        clr(REM);
        cyc(INS, 1'b0, "R5 removal clear while present");
        sten[6] = 1'b0;
        cyc('0, 1'b0, "R8 insert disabled");
        sten[6] = 1'b1;
        rd = 1'b1;
        cyc(RDR, 1'b0, "R7 read-ready rising edge");
        clr('0);
        cyc(RDR, 1'b0, "R3 write of zero no effect");
        clr(16'hFE0F);
        cyc(RDR, 1'b0, "R2 R3 other positions leave bit 5");
        clr(RDR);
        cyc('0, 1'b0, "R3 clear read-ready");
        cyc('0, 1'b0, "R7 steady high no reset");
        rd = 1'b0;
        cyc('0, 1'b0, "R7 falling edge no set");
        rd = 1'b1;
        clr(RDR);
        cyc(RDR, 1'b0, "R10 set beats clear");
        wr = 1'b1;
        cyc(RDR | WRR, 1'b0, "R7 write-ready rising edge");
        clr(RDR | WRR);
        cyc('0, 1'b0, "R3 clear both buffer flags");
        creq = 1'b1;
        sgen = 16'hFEFF;
        cyc(CIR, 1'b0, "R6 R9 card irq set, not signalled");
        sgen = 16'h0100;
        cyc(CIR, 1'b1, "R9 card irq signalled");
        clr(CIR);
        cyc(CIR, 1'b1, "R6 clear while request active");
        creq = 1'b0;
        cyc(CIR, 1'b1, "R6 flag holds after request drops");
        clr(CIR);
        cyc('0, 1'b0, "R6 clear after request gone");
        sten[8] = 1'b0;
        creq = 1'b1;
        cyc('0, 1'b0, "R8 card irq disabled");
        creq = 1'b0;
        sten[8] = 1'b1;
        wr = 1'b0;
        sgen = 16'h0010;
        cyc('0, 1'b0, "R9 nothing set");
        wr = 1'b1;
        cyc(WRR, 1'b1, "R9 write-ready signalled");
        sten = '0;
        cyc('0, 1'b0, "R8 all disabled");
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule